// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static RAM with a 22-bit address, a 1-bit input data pin and a separate 1-bit output data pin. The RAM is controlled by active-low select, write-strobe and output-drive pins. The host presents one request at a time: an address, a write flag and write data, held for one cycle. The sequencer then drives the RAM pins through a fixed phase order and pulses a ready strobe when the access is complete. A read returns the sampled data alongside that strobe.

Each timing limit is given as a parameter in nanoseconds, together with the clock period. The limits are converted to whole clock cycles, rounded up, with at least one cycle per phase. The sequencer holds every phase for at least its converted length. It follows three pin rules:
- A write happens only while select and write strobe are both low, and it ends when they rise together.
- The address and write data are settled one cycle before select falls.
- Neither the address nor the write data moves while select is low.

When idle, and after reset, all three control pins are high.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever the sequencer is idle or returning ready, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1 and `host_ready` is 0 outside its completion pulse.
- R2: A write drives `mem_cs_n` and `mem_we_n` low on the same clock edge. Both stay low for exactly WP_CYC cycles and rise together on one edge. WP_CYC is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_AW_NS/CLK_NS) and ceil(T_DW_NS/CLK_NS), and at least 1 (2 with defaults). The RAM stores `mem_din` at that edge.
- R3: `mem_addr` and `mem_din` take the request values one cycle before select falls. They stay unchanged until select has risen again.
- R4: `mem_oe_n` stays 1 whenever `mem_we_n` is 0, and `mem_we_n` is 0 only while `mem_cs_n` is 0.
- R5: A read drives `mem_cs_n` and `mem_oe_n` low together, with `mem_we_n` held at 1, for exactly RD_CYC cycles. RD_CYC is the larger of ceil(T_AA_NS/CLK_NS) and ceil(T_OE_NS/CLK_NS), and at least 1 (3 with defaults). `mem_dout` is sampled on the edge that raises both pins and appears on `host_rdata` with the ready pulse.
- R6: `host_ready` is a one-cycle pulse. It comes 1+WP_CYC+REC_CYC cycles after a write is accepted, where REC_CYC is max(1, ceil(T_WC_NS/CLK_NS)-WP_CYC) (1 with defaults). It comes 1+RD_CYC cycles after a read is accepted.
- R7: A `host_req` raised while an access is in progress is ignored. It causes no RAM access and no ready pulse.
- R8: `mem_addr` does not change on any cycle in which `mem_cs_n` is low on both sides of the edge.
- R9: A request raised in the cycle where `host_ready` is high is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, sampled only when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Request address |
| host_wdata | input | 1 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 1 | Last read value, valid with ready |
| mem_addr | output | 22 | RAM address pins |
| mem_din | output | 1 | RAM input data pin |
| mem_dout | input | 1 | RAM output data pin |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output drive, active low |

## Verification
Two events can fall on the same clock edge. In the first, the read sample is taken while select and output drive are released. In the second, a completion pulse is returned while the host already holds its next request. The bench provokes the second case by raising a new request in the very cycle ready is seen, and it also injects a request in the middle of a read. A timed RAM model returns unknown data until the access time has passed, so a sample taken too early, too late or at the wrong address shows up as a mismatch in the scoreboard. Any extra or missing ready pulse shows up as a queue that is empty or left over.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_ADDR,
    ST_W_PULSE,
    ST_W_REC,
    ST_R_ADDR,
    ST_R_WAIT
  } seq_state_e;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (capture) begin
      dout <= din;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int AW      = 22,
  parameter int DW      = 1,
  parameter int CW      = 4,
  parameter int WP_CYC  = 2,
  parameter int RD_CYC  = 3,
  parameter int REC_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_din,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          rd_capture
);

  seq_state_e state;

  // Timer reload points and the read sample strobe.
  always_comb begin
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    case (state)
      ST_W_ADDR: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(WP_CYC - 1);
      end
      ST_W_PULSE: begin
        tmr_load = tmr_expired;
        tmr_val  = CW'(REC_CYC - 1);
      end
      ST_R_ADDR: begin
        tmr_load = 1'b1;
        tmr_val  = CW'(RD_CYC - 1);
      end
      ST_R_WAIT: rd_capture = tmr_expired;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      host_ready <= 1'b0;
      mem_addr   <= '0;
      mem_din    <= '0;
    end else begin
      host_ready <= 1'b0;
      case (state)
        ST_IDLE: if (host_req) begin
          mem_addr <= host_addr;
          if (host_wr) begin
            mem_din <= host_wdata;
            state   <= ST_W_ADDR;
          end else begin
            state   <= ST_R_ADDR;
          end
        end
        ST_W_ADDR: begin
          mem_cs_n <= 1'b0;
          mem_we_n <= 1'b0;
          state    <= ST_W_PULSE;
        end
        ST_W_PULSE: if (tmr_expired) begin
          mem_cs_n <= 1'b1;
          mem_we_n <= 1'b1;
          state    <= ST_W_REC;
        end
        ST_W_REC: if (tmr_expired) begin
          host_ready <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_R_ADDR: begin
          mem_cs_n <= 1'b0;
          mem_oe_n <= 1'b0;
          state    <= ST_R_WAIT;
        end
        ST_R_WAIT: if (tmr_expired) begin
          mem_cs_n   <= 1'b1;
          mem_oe_n   <= 1'b1;
          host_ready <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 1,
  parameter int CLK_NS   = 4,
  parameter int T_WC_NS  = 10,
  parameter int T_WP_NS  = 7,
  parameter int T_AW_NS  = 7,
  parameter int T_DW_NS  = 5,
  parameter int T_AA_NS  = 10,
  parameter int T_OE_NS  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_din,
  input  logic [DW-1:0] mem_dout,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int RD_CYC  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC = imax(1, WC_CYC - WP_CYC);
  localparam int MAX_CYC = imax(WP_CYC, imax(RD_CYC, REC_CYC));
  localparam int CW      = imax(1, $clog2(MAX_CYC + 1));

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          rd_capture;

  sram_seq_fsm #(
    .AW(AW), .DW(DW), .CW(CW),
    .WP_CYC(WP_CYC), .RD_CYC(RD_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready),
    .mem_addr(mem_addr), .mem_din(mem_din),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .rd_capture(rd_capture)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst),
    .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst),
    .capture(rd_capture), .din(mem_dout),
    .dout(host_rdata)
  );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int AW     = 22,
  parameter int DW     = 1,
  parameter int WP_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_din,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  logic [31:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)            we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1;
    else                we_low_cnt <= '0;
  end

  a_r1_idle_on_ready: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

  a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= 32'(WP_CYC)));

  a_r2_joint_release: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $rose(mem_cs_n));

  a_r3_din_hold_write: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_din));

  a_r4_we_within_cs: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  a_r8_addr_hold_sel: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .AW(AW), .DW(DW), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready),
  .mem_addr(mem_addr), .mem_din(mem_din),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
);

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;

  localparam int CLK_PERIOD = 4;
  localparam int AW = 22;
  localparam int WP  = ((7 + CLK_PERIOD - 1) / CLK_PERIOD > (5 + CLK_PERIOD - 1) / CLK_PERIOD)
                       ? (7 + CLK_PERIOD - 1) / CLK_PERIOD : (5 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RD  = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WC  = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int REC = (WC - WP > 1) ? WC - WP : 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [0:0]    host_wdata = '0;
  logic          host_ready;
  logic [0:0]    host_rdata;
  logic [AW-1:0] mem_addr;
  logic [0:0]    mem_din;
  logic [0:0]    mem_dout;
  logic          mem_cs_n, mem_we_n, mem_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  logic ref_mem [int unsigned];
  logic model_mem [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Timed RAM model: data only after the access time, writes at end of window.
  int          rd_low_cnt = 0;
  int          we_low_cnt = 0;
  logic        in_win = 1'b0;
  logic [AW-1:0] win_addr;
  logic        win_d;
  logic        prev_cs_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic        prev_din = 1'b0;
  logic        prev_we_n = 1'b1;

  always @* begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n && rd_low_cnt >= RD - 1 &&
        model_mem.exists(int'(mem_addr)))
      mem_dout = model_mem[int'(mem_addr)];
    else
      mem_dout = 1'bx;
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (!mem_cs_n && !mem_oe_n) rd_low_cnt <= rd_low_cnt + 1;
      else begin
        if (rd_low_cnt != 0) check("R5 read select width", rd_low_cnt, RD);
        rd_low_cnt <= 0;
      end
      if (!mem_we_n) we_low_cnt <= we_low_cnt + 1;
      else begin
        if (we_low_cnt != 0) check("R2 write pulse width", we_low_cnt, WP);
        we_low_cnt <= 0;
      end
      if (!mem_cs_n && !mem_we_n) begin
        in_win   <= 1'b1;
        win_addr <= mem_addr;
        win_d    <= mem_din[0];
      end else if (in_win) begin
        model_mem[int'(win_addr)] = win_d;
        in_win <= 1'b0;
        check("R2 select released with strobe", {mem_cs_n, mem_we_n}, 2'b11);
      end
      if (!mem_we_n && !mem_oe_n) check("R4 output drive off in write", 1, 0);
      if (!mem_we_n &&  mem_cs_n) check("R4 strobe only with select", 1, 0);
      if (!mem_cs_n && !prev_cs_n && mem_addr != prev_addr)
        check("R8 address moved under select", mem_addr, prev_addr);
      if (!mem_cs_n && prev_cs_n)
        check("R3 address settled before select", mem_addr, prev_addr);
      if (!mem_we_n && !prev_we_n && mem_din[0] != prev_din)
        check("R3 write data moved", mem_din, prev_din);
      prev_cs_n <= mem_cs_n;
      prev_we_n <= mem_we_n;
      prev_addr <= mem_addr;
      prev_din  <= mem_din[0];
    end
  end

  // Scoreboard monitor: each ready pops one expected item.
  logic prev_ready = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (host_ready && prev_ready) check("R6 ready longer than one cycle", 1, 0);
      if (host_ready) begin
        if (exp_q.size() == 0) check("R7 unexpected ready", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e >= 0) check("R5 read data", host_rdata, e);
        end
      end
      prev_ready <= host_ready;
    end
  end

  // Driver: one request; inject=1 pulses a stray write mid-access.
  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic d,
                       input bit no_wait, input bit inject, input logic [AW-1:0] ia);
    int lat;
    if (!no_wait) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    if (wr) begin
      ref_mem[int'(a)] = d;
      exp_q.push_back(-1);
    end else begin
      exp_q.push_back(int'(ref_mem[int'(a)]));
    end
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    if (inject) begin
      @(negedge clk); lat++;
      host_req = 1'b1; host_wr = 1'b1; host_addr = ia; host_wdata = ~ref_mem[int'(ia)];
      @(negedge clk); lat++;
      host_req = 1'b0;
    end
    while (!host_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (wr) check("R6 write latency", lat, 2 + WP + REC);
    else    check("R6 read latency",  lat, 2 + RD);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset pins", {mem_cs_n, mem_we_n, mem_oe_n, host_ready}, 4'b1110);

    issue(1'b1, 22'h000000, 1'b1, 1'b0, 1'b0, '0);
    issue(1'b1, 22'h000001, 1'b0, 1'b0, 1'b0, '0);
    issue(1'b1, 22'h3FFFFF, 1'b1, 1'b0, 1'b0, '0);
    issue(1'b1, 22'h155555, 1'b0, 1'b0, 1'b0, '0);
    check("R1 idle pins after write", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    issue(1'b0, 22'h000000, 1'b0, 1'b0, 1'b0, '0);
    issue(1'b0, 22'h3FFFFF, 1'b0, 1'b0, 1'b0, '0);
    issue(1'b0, 22'h000001, 1'b0, 1'b0, 1'b0, '0);
    issue(1'b0, 22'h155555, 1'b0, 1'b0, 1'b0, '0);
    // R9: back-to-back requests raised in the ready cycle
    issue(1'b1, 22'h2AAAAA, 1'b1, 1'b0, 1'b0, '0);
    issue(1'b0, 22'h2AAAAA, 1'b0, 1'b1, 1'b0, '0);
    issue(1'b1, 22'h000001, 1'b1, 1'b1, 1'b0, '0);
    issue(1'b0, 22'h000001, 1'b0, 1'b1, 1'b0, '0);
    // R7: stray write injected during a read must leave 0x155555 unchanged
    issue(1'b0, 22'h000000, 1'b0, 1'b0, 1'b1, 22'h155555);
    repeat (4) @(negedge clk);
    check("R7 no access after stray request", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    issue(1'b0, 22'h155555, 1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", exp_q.size(), 0);
    check("R1 idle pins at end", {mem_cs_n, mem_we_n, mem_oe_n, host_ready}, 4'b1110);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule